// File: doc/BRIEF.md
# Wiper Store and Recall Sequencer

This block owns the position register of a 128-tap digital potentiometer and the backup register that keeps a position across power cycles. The backup register is modelled as an ordinary register paired with a programming timer; the programming timer stands in for the few milliseconds a real nonvolatile cell needs. Out of reset, the wiper sits at mid-scale (64). Once the supply is reported stable and a programmable settle delay has run out, the saved position is copied into the wiper. From then on, the block accepts position writes from the serial-bus front end.

A write carries a target flag. A volatile write moves only the wiper. A backup write moves the wiper at once. It then holds the block busy for a programmed number of clock cycles, and at the end of that period it commits the same position into the backup register. The current position is also decoded into a one-hot select of the 128 tap switches.

Writes arrive on a valid/ready channel. A transfer happens on a rising clock edge where both `wr_valid` and `wr_ready` are high. The source must hold `wr_valid`, `wr_nv` and `wr_data` steady until that edge. `wr_ready` is low before the first recall completes and for the whole of a programming period, so the block takes nothing in those windows. Requests that arrive during programming are discarded by the bus front end, which ignores the bus while `busy` is high.

Top module: `wiper_store_seq`

## Requirements
- R1: In reset, and in the first cycle after reset, `wiper` is 64 (binary 1000000) and `stored` equals the parameter `STORE_INIT`; `busy` and `wr_ready` are low.
- R2: Before the first recall, `wiper` stays at 64 and `wr_ready` stays low; a `wr_valid` presented in that window changes nothing.
- R3: The first edge that samples `supply_ok` high starts the settle delay. Exactly `RECALL_CYCLES` edges later, `wiper` takes the value of `stored` and `wr_ready` rises at that same edge. If `supply_ok` is sampled low before then, the delay is abandoned and restarts from the next edge that samples it high.
- R4: A transfer with `wr_nv`=0 sets `wiper` to `wr_data[6:0]` at the transfer edge. Bit 7 of `wr_data` is ignored. `stored` and `busy` do not change.
- R5: A transfer with `wr_nv`=1 sets `wiper` to `wr_data[6:0]` at the transfer edge. `busy` is then high for exactly `PROG_CYCLES` cycles, and `wr_ready` is low for all of them.
- R6: `stored` takes the written position at the edge where `busy` falls. From that edge on, `wiper` and `stored` are equal, and a new transfer may happen at the very next edge.
- R7: While `busy` is high, `wr_valid` has no effect: `wiper` and `stored` hold their values.
- R8: `tap_sel` has exactly one bit set, and that bit's index equals `wiper`.
- R9: `busy` and `wr_ready` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset (power-up) |
| supply_ok | input | 1 | High when the supply is stable |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Block can take a write this cycle |
| wr_nv | input | 1 | 1: also program the backup register; 0: wiper only |
| wr_data | input | TAP_BITS+1 (8) | Position byte; the MSB is ignored |
| busy | output | 1 | Backup programming in progress |
| wiper | output | TAP_BITS (7) | Current wiper position |
| stored | output | TAP_BITS (7) | Backup register contents |
| tap_sel | output | 2**TAP_BITS (128) | One-hot tap switch select |

## Verification
The bound assertions check several properties on every cycle:
- the one-hot tap select always matches the wiper;
- busy and ready are exclusive;
- the wiper stays at mid-scale until the block first becomes ready;
- the wiper holds still during programming;
- the backup register equals the wiper when busy falls;
- each accepted write lands in the wiper one edge later.

Only the bench scenarios can show the exact edge counts of the settle delay and of the programming window. The same holds for the restart of the settle delay when the supply drops, for the discarded MSB, for back-to-back backup writes, and for the backup register reloading its initial content after a second reset.

// File: rtl/wpr_pkg.sv
package wpr_pkg;

  // Sequencer phases of the wiper store/recall controller.
  typedef enum logic [1:0] {
    SEQ_POWERUP = 2'd0,  // wiper parked at mid-scale, waiting for supply
    SEQ_SETTLE  = 2'd1,  // supply seen, counting recall delay
    SEQ_RUN     = 2'd2,  // accepting writes
    SEQ_PROGRAM = 2'd3   // backup register being programmed
  } seq_state_t;

endpackage

// File: rtl/wpr_delay_timer.sv
// Loadable down-counter; expired is high while the count sits at zero.
module wpr_delay_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/wpr_tap_decoder.sv
// Binary position to one-hot tap switch select.
module wpr_tap_decoder #(
  parameter int TAP_BITS = 7,
  localparam int TAPS    = 2 ** TAP_BITS
) (
  input  logic [TAP_BITS-1:0] code,
  output logic [TAPS-1:0]     sel
);

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign sel[i] = (code == TAP_BITS'(i));
  end

endmodule

// File: rtl/wiper_store_seq.sv
module wiper_store_seq
  import wpr_pkg::*;
#(
  parameter int                  TAP_BITS      = 7,
  parameter int                  RECALL_CYCLES = 1250000,  // must be >= 1
  parameter int                  PROG_CYCLES   = 1250000,  // must be >= 1
  parameter logic [TAP_BITS-1:0] STORE_INIT    = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     supply_ok,
  input  logic                     wr_valid,
  output logic                     wr_ready,
  input  logic                     wr_nv,
  input  logic [TAP_BITS:0]        wr_data,
  output logic                     busy,
  output logic [TAP_BITS-1:0]      wiper,
  output logic [TAP_BITS-1:0]      stored,
  output logic [(2**TAP_BITS)-1:0] tap_sel
);

  localparam logic [TAP_BITS-1:0] MID_CODE = TAP_BITS'(1) << (TAP_BITS - 1);
  localparam int RC_W = $clog2(RECALL_CYCLES + 1);
  localparam int PC_W = $clog2(PROG_CYCLES + 1);
  localparam logic [RC_W-1:0] RC_LOAD = RC_W'(RECALL_CYCLES - 1);
  localparam logic [PC_W-1:0] PC_LOAD = PC_W'(PROG_CYCLES - 1);

  seq_state_t          state_q, state_d;
  logic [TAP_BITS-1:0] wiper_q, stored_q, stage_q;
  logic                rc_load, rc_expired;
  logic                pc_load, pc_expired;
  logic                take, recall_fire, commit_fire;

  // Settle-delay timer for the power-up recall.
  wpr_delay_timer #(.CNT_W(RC_W)) u_recall_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (rc_load),
    .load_val (RC_LOAD),
    .expired  (rc_expired)
  );

  // Programming-period timer for backup writes.
  wpr_delay_timer #(.CNT_W(PC_W)) u_prog_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (pc_load),
    .load_val (PC_LOAD),
    .expired  (pc_expired)
  );

  assign wr_ready    = (state_q == SEQ_RUN);
  assign busy        = (state_q == SEQ_PROGRAM);
  assign take        = wr_valid && wr_ready;
  assign recall_fire = (state_q == SEQ_SETTLE) && supply_ok && rc_expired;
  assign commit_fire = (state_q == SEQ_PROGRAM) && pc_expired;

  always_comb begin
    state_d = state_q;
    rc_load = 1'b0;
    pc_load = 1'b0;
    unique case (state_q)
      SEQ_POWERUP: begin
        if (supply_ok) begin
          state_d = SEQ_SETTLE;
          rc_load = 1'b1;
        end
      end
      SEQ_SETTLE: begin
        if (!supply_ok) begin
          state_d = SEQ_POWERUP;
        end else if (rc_expired) begin
          state_d = SEQ_RUN;
        end
      end
      SEQ_RUN: begin
        if (take && wr_nv) begin
          state_d = SEQ_PROGRAM;
          pc_load = 1'b1;
        end
      end
      SEQ_PROGRAM: begin
        if (pc_expired) begin
          state_d = SEQ_RUN;
        end
      end
      default: state_d = SEQ_POWERUP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= SEQ_POWERUP;
      wiper_q  <= MID_CODE;
      stored_q <= STORE_INIT;
      stage_q  <= '0;
    end else begin
      state_q <= state_d;
      if (recall_fire) begin
        wiper_q <= stored_q;
      end else if (take) begin
        wiper_q <= wr_data[TAP_BITS-1:0];
      end
      if (take && wr_nv) begin
        stage_q <= wr_data[TAP_BITS-1:0];
      end
      if (commit_fire) begin
        stored_q <= stage_q;
      end
    end
  end

  assign wiper  = wiper_q;
  assign stored = stored_q;

  wpr_tap_decoder #(.TAP_BITS(TAP_BITS)) u_tap_dec (
    .code (wiper_q),
    .sel  (tap_sel)
  );

endmodule

// File: rtl/wpr_checker.sv
module wpr_checker #(
  parameter int TAP_BITS = 7
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     supply_ok,
  input logic                     wr_valid,
  input logic                     wr_ready,
  input logic                     wr_nv,
  input logic [TAP_BITS:0]        wr_data,
  input logic                     busy,
  input logic [TAP_BITS-1:0]      wiper,
  input logic [TAP_BITS-1:0]      stored,
  input logic [(2**TAP_BITS)-1:0] tap_sel
);

  localparam logic [TAP_BITS-1:0] MID_CODE = TAP_BITS'(1) << (TAP_BITS - 1);

  assert_mid_until_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ready && !busy) |-> (wiper == MID_CODE));

  assert_recall_copies_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wr_ready) && !$past(busy)) |-> (wiper == stored));

  assert_volatile_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !wr_nv) |=>
      (wiper == $past(wr_data[TAP_BITS-1:0])) && $stable(stored) && !busy);

  assert_backup_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_nv) |=>
      busy && (wiper == $past(wr_data[TAP_BITS-1:0])));

  assert_commit_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (stored == wiper));

  assert_hold_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(wiper));

  assert_onehot_tap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(tap_sel) == 1) && tap_sel[wiper]);

  assert_busy_ready_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && wr_ready));

endmodule

bind wiper_store_seq wpr_checker #(.TAP_BITS(TAP_BITS)) u_wpr_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .supply_ok (supply_ok),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_nv     (wr_nv),
  .wr_data   (wr_data),
  .busy      (busy),
  .wiper     (wiper),
  .stored    (stored),
  .tap_sel   (tap_sel)
);

// File: tb/wiper_store_seq_tb_top.sv
module wiper_store_seq_tb_top;

  localparam int         TB    = 7;
  localparam int         RC    = 5;
  localparam int         PC    = 6;
  localparam logic [6:0] SINIT = 7'd42;

  logic         clk = 1'b0;
  logic         rst_n, supply_ok, wr_valid, wr_ready, wr_nv, busy;
  logic [7:0]   wr_data;
  logic [6:0]   wiper, stored;
  logic [127:0] tap_sel;

  always #2 clk = ~clk;  // 250 MHz

  wiper_store_seq #(
    .TAP_BITS(TB), .RECALL_CYCLES(RC), .PROG_CYCLES(PC), .STORE_INIT(SINIT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_nv(wr_nv), .wr_data(wr_data), .busy(busy),
    .wiper(wiper), .stored(stored), .tap_sel(tap_sel)
  );

  typedef struct {
    int    due;
    string req;
    int    w;
    int    s;
    bit    b;
    bit    r;
  } exp_t;

  exp_t q[$];
  int   cyc   = 0;
  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops expected items when due and compares them at the ports.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin : pop_blk
      exp_t         e;
      logic [127:0] exp_tap;
      e       = q.pop_front();
      exp_tap = 128'b1 << e.w;
      n_chk++;
      if (e.due != cyc || wiper !== 7'(e.w) || stored !== 7'(e.s) ||
          busy !== e.b || wr_ready !== e.r || tap_sel !== exp_tap) begin
        n_err++;
        $display("FAIL %s cyc=%0d due=%0d wiper=%0d exp %0d stored=%0d exp %0d busy=%b exp %b ready=%b exp %b tap_ok=%b",
                 e.req, cyc, e.due, wiper, e.w, stored, e.s, busy, e.b,
                 wr_ready, e.r, (tap_sel === exp_tap));
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_at(int d, string req, int w, int s, bit b, bit r);
    exp_t e;
    e = '{due: cyc + d, req: req, w: w, s: s, b: b, r: r};
    q.push_back(e);
  endtask

  task automatic send(bit nv, logic [7:0] d);
    wr_valid = 1'b1;
    wr_nv    = nv;
    wr_data  = d;
    tick();
    wr_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    rst_n     = 1'b0;
    supply_ok = 1'b0;
    wr_valid  = 1'b0;
    wr_nv     = 1'b0;
    wr_data   = 8'h00;
    repeat (3) tick();
    rst_n = 1'b1;
    expect_at(0, "R1", 64, 42, 0, 0);
    tick();

    // R2: supply low, request presented, nothing moves
    wr_valid = 1'b1;
    wr_data  = 8'h05;
    for (int i = 0; i < 6; i++) begin
      expect_at(0, "R2", 64, 42, 0, 0);
      tick();
    end
    wr_valid = 1'b0;

    // R3: supply drops during settle, delay restarts
    supply_ok = 1'b1;
    tick();
    tick();
    supply_ok = 1'b0;
    tick();
    for (int i = 0; i < RC + 2; i++) begin
      expect_at(0, "R3", 64, 42, 0, 0);
      tick();
    end
    supply_ok = 1'b1;
    for (int k = 1; k <= RC; k++) expect_at(k, "R3", 64, 42, 0, 0);
    expect_at(RC + 1, "R3", 42, 42, 0, 1);
    repeat (RC + 1) tick();

    // R4: volatile writes, MSB ignored; R8 boundary taps
    expect_at(1, "R4", 127, 42, 0, 1);
    send(1'b0, 8'hFF);
    expect_at(1, "R8", 0, 42, 0, 1);
    send(1'b0, 8'h80);
    expect_at(1, "R4", 51, 42, 0, 1);
    send(1'b0, 8'h33);

    // R5/R6/R7/R9: backup write with requests held during programming
    expect_at(1, "R5", 19, 42, 1, 0);
    expect_at(2, "R9", 19, 42, 1, 0);
    for (int k = 3; k <= PC; k++) expect_at(k, "R7", 19, 42, 1, 0);
    expect_at(PC + 1, "R6", 19, 19, 0, 1);
    wr_valid = 1'b1;
    wr_nv    = 1'b1;
    wr_data  = 8'h93;
    tick();
    wr_nv   = 1'b0;
    wr_data = 8'h55;
    repeat (PC - 2) tick();
    wr_valid = 1'b0;
    repeat (2) tick();

    // R6: back-to-back backup write on the first ready edge
    for (int k = 1; k <= PC; k++) expect_at(k, "R5", 127, 19, 1, 0);
    expect_at(PC + 1, "R6", 127, 127, 0, 1);
    send(1'b1, 8'h7F);
    repeat (PC) tick();

    // R4: volatile write leaves the backup value alone
    expect_at(1, "R4", 1, 127, 0, 1);
    send(1'b0, 8'h01);

    // R1 again: second reset with supply already stable, then recall (R3)
    rst_n = 1'b0;
    tick();
    expect_at(0, "R1", 64, 42, 0, 0);
    rst_n = 1'b1;
    for (int k = 1; k <= RC; k++) expect_at(k, "R3", 64, 42, 0, 0);
    expect_at(RC + 1, "R3", 42, 42, 0, 1);
    repeat (RC + 3) tick();

    if (q.size() != 0) begin
      n_chk++;
      n_err++;
      $display("FAIL scoreboard: %0d items unchecked, expected 0", q.size());
    end
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

endmodule